// File: doc/BRIEF.md
# 8-bit ALU with Status Flag Register

This block is the arithmetic core of a small 8-bit RISC processor. In one cycle it combines a destination operand with a second operand, which is either a register value or an immediate, and forms an 8-bit result. It also forms the new values of seven status flags. The result, and a write-enable telling the register file whether to keep it, are combinational. The flags sit in a register inside the block, and that register is loaded on the clock edge at which `op_en` is high.

Every operation owns a fixed set of flags. It rewrites only those and leaves the rest as they were. Because of this, a carry can run from one byte operation to the next, and a multi-byte compare leaves the correct zero flag behind. Subtract-with-borrow and compare-with-borrow clear Z but never set it. Single-flag set and clear are also supported. A branch condition is evaluated at all times from the registered flags: a chosen flag set, a chosen flag clear, signed greater-or-equal, or signed less-than. Instruction decode, the register file and memory access are left to the surrounding core.

Top module: `alu8_flags`

## Requirements
- R1: `flags` holds C at bit 0, Z 1, N 2, V 3, S 4, H 5 and T 6. ADD (op 0) and ADC (op 1, which adds C) drive `result` with the sum and update C, Z, N, V, S and H. C is the carry out of bit 7 and H is the carry out of bit 3.
- R2: SUB (op 2) and SBC (op 3, which also subtracts C) drive `result` with the difference and update C, Z, N, V, S and H. C is the borrow out of bit 7 and H is the borrow out of bit 3. The immediate forms use the same codes with the immediate on `rr_val`.
- R3: CP (op 4) and CPC (op 5) set the flags exactly as SUB and SBC do, and hold `wr_en` low.
- R4: SBC and CPC set Z only when the result is zero and Z was already 1. A nonzero result clears Z.
- R5: AND (6), OR (7) and EOR (8) update Z and N, clear V, and set S to N. C, H and T keep their values.
- R6: INC (11) and DEC (12) update Z, N, V and S only. V is set when the operand is 0x7F for INC, or 0x80 for DEC.
- R7: COM (9) returns 0xFF minus the operand, sets C to 1 and clears V. NEG (10) returns 0x00 minus the operand, sets C when the result is nonzero, sets V when the result is 0x80, and also updates H.
- R8: LSL (13) and LSR (14) shift in 0. ROL (15) and ROR (16) shift in the old C. ASR (17) keeps bit 7. Each of them puts the bit shifted out into C, updates Z and N, and sets V to N XOR C.
- R9: SWAP (18) exchanges the two nibbles, and SER (19) returns 0xFF. Neither one changes any flag.
- R10: FSET (20) and FCLR (21) force the flag selected by `bit_sel` to 1 or 0 and leave all the other flags alone. `bit_sel` = 7 changes nothing. Neither operation asserts `wr_en`.
- R11: Every operation that updates N or V leaves S equal to N XOR V.
- R12: `br_taken` comes from the registered flags. `br_mode` 0 means the flag at `bit_sel` is 1, 1 means it is 0, 2 means N XOR V is 0, and 3 means N XOR V is 1. `bit_sel` = 7 reads as a 0.
- R13: Synchronous reset clears all flags. While `op_en` is low, the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Load the new flags at this edge |
| op_sel | input | 5 | Operation code |
| rd_val | input | 8 | Destination operand |
| rr_val | input | 8 | Source operand or immediate |
| bit_sel | input | 3 | Flag index for set, clear and branch test |
| br_mode | input | 2 | Branch condition select |
| result | output | 8 | Operation result (combinational) |
| wr_en | output | 1 | Result is to be written back |
| flags | output | 7 | Registered status flags |
| br_taken | output | 1 | Branch condition is true |

## Verification
`result` and `wr_en` settle in the same cycle as their operands, since no register lies on their path. The bench samples them 1 ns after driving at the falling edge, before the next rising edge. The new flags appear one rising edge after the operation, so the bench compares them at the following falling edge. `br_taken` reads the flags register, so it is checked after the edge that loaded those flags. Starting flag values are loaded through FSET and FCLR, one flag per cycle, before each vector.

// File: rtl/alu8_pkg.sv
// Shared definitions for the 8-bit ALU: operation codes and flag bit positions.
// Assumes a 7-entry flag word; the positions below are visible at the port.
package alu8_pkg;

    localparam int FLAG_W = 7;
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;
    localparam int F_T = 6;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CP   = 5'd4,  OP_CPC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
        OP_EOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
        OP_ROR  = 5'd16, OP_ASR  = 5'd17, OP_SWAP = 5'd18, OP_SER  = 5'd19,
        OP_FSET = 5'd20, OP_FCLR = 5'd21
    } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
// Shared adder/subtractor. A subtract is done by adding the inverted operand.
// Carry and half carry come back as a borrow when sub is set.
// Assumes DW is even, so that the half-carry boundary falls on DW/2.
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          c_out,
    output logic          h_out,
    output logic          v_out
);
    localparam int NIB = DW / 2;

    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic [DW:0]   full;
    logic [NIB:0]  low;

    // Add with inverted operand and carry for subtract; report borrows
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
        low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
        sum   = full[DW-1:0];
        c_out = sub ? ~full[DW] : full[DW];
        h_out = sub ? ~low[NIB] : low[NIB];
        v_out = (a[DW-1] == b_eff[DW-1]) && (full[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/alu8_datapath.sv
// Result datapath: routes operands into the shared adder, then picks the
// arithmetic, logic, shift or nibble-swap result. cin is the current carry flag.
module alu8_datapath
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] rd,
    input  logic [DW-1:0] rr,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          c_ar,
    output logic          h_ar,
    output logic          v_ar,
    output logic          sh_c
);
    localparam int NIB = DW / 2;

    logic [DW-1:0] as_a, as_b, as_sum;
    logic          as_ci, as_sub;

    // Choose adder operands: NEG is 0 - rd, INC and DEC use a constant one
    always_comb begin
        as_a   = rd;
        as_b   = rr;
        as_ci  = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC:         as_ci = cin;
            OP_SUB, OP_CP:  as_sub = 1'b1;
            OP_SBC, OP_CPC: begin as_sub = 1'b1; as_ci = cin; end
            OP_NEG:         begin as_a = '0; as_b = rd; as_sub = 1'b1; end
            OP_INC:         as_b = DW'(1);
            OP_DEC:         begin as_b = DW'(1); as_sub = 1'b1; end
            default:        ;
        endcase
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .a(as_a), .b(as_b), .cin(as_ci), .sub(as_sub),
        .sum(as_sum), .c_out(c_ar), .h_out(h_ar), .v_out(v_ar)
    );

    // Select the result and the bit a shift pushes out
    always_comb begin
        res  = '0;
        sh_c = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
            OP_NEG, OP_INC, OP_DEC: res = as_sum;
            OP_AND:  res = rd & rr;
            OP_OR:   res = rd | rr;
            OP_EOR:  res = rd ^ rr;
            OP_COM:  res = ~rd;
            OP_LSL:  begin res = {rd[DW-2:0], 1'b0};   sh_c = rd[DW-1]; end
            OP_ROL:  begin res = {rd[DW-2:0], cin};    sh_c = rd[DW-1]; end
            OP_LSR:  begin res = {1'b0, rd[DW-1:1]};   sh_c = rd[0]; end
            OP_ROR:  begin res = {cin, rd[DW-1:1]};    sh_c = rd[0]; end
            OP_ASR:  begin res = {rd[DW-1], rd[DW-1:1]}; sh_c = rd[0]; end
            OP_SWAP: res = {rd[NIB-1:0], rd[DW-1:NIB]};
            OP_SER:  res = '1;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flag_ctl.sv
// Flag update control: for each operation, produces the new flag values and
// a mask of the flags that operation owns. It also decides write-back.
// Bits outside the mask are ignored by the flag register.
module alu8_flag_ctl
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e             op,
    input  logic [DW-1:0]       res,
    input  logic [FLAG_W-1:0]   fq,
    input  logic                c_ar,
    input  logic                h_ar,
    input  logic                v_ar,
    input  logic                sh_c,
    input  logic [2:0]          bit_sel,
    output logic [FLAG_W-1:0]   nxt,
    output logic [FLAG_W-1:0]   mask,
    output logic                wr
);
    logic zr, ng;

    assign zr = (res == '0);
    assign ng = res[DW-1];

    // Per-operation flag values, ownership mask and write-back decision
    always_comb begin
        nxt  = fq;
        mask = '0;
        wr   = 1'b1;
        nxt[F_Z] = zr;
        nxt[F_N] = ng;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_CP, OP_NEG: begin
                nxt[F_C] = c_ar; nxt[F_H] = h_ar; nxt[F_V] = v_ar;
                mask = 7'b0111111;
            end
            OP_SBC, OP_CPC: begin
                nxt[F_C] = c_ar; nxt[F_H] = h_ar; nxt[F_V] = v_ar;
                nxt[F_Z] = zr & fq[F_Z];
                mask = 7'b0111111;
            end
            OP_AND, OP_OR, OP_EOR: begin
                nxt[F_V] = 1'b0;
                mask = 7'b0011110;
            end
            OP_INC, OP_DEC: begin
                nxt[F_V] = v_ar;
                mask = 7'b0011110;
            end
            OP_COM: begin
                nxt[F_C] = 1'b1; nxt[F_V] = 1'b0;
                mask = 7'b0011111;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
                nxt[F_C] = sh_c; nxt[F_V] = ng ^ sh_c;
                mask = 7'b0011111;
            end
            OP_SWAP, OP_SER: ;
            OP_FSET, OP_FCLR: begin
                nxt = fq;
                wr  = 1'b0;
                if (bit_sel != 3'd7) begin
                    mask[bit_sel]    = 1'b1;
                    nxt[bit_sel]     = (op == OP_FSET);
                end
            end
            default: wr = 1'b0;
        endcase
        if (op == OP_CP || op == OP_CPC) wr = 1'b0;
        nxt[F_S] = nxt[F_N] ^ nxt[F_V];
        if (op == OP_FSET || op == OP_FCLR) begin
            if (bit_sel == 3'(F_S)) nxt[F_S] = (op == OP_FSET);
            else                    nxt[F_S] = fq[F_S];
        end
    end
endmodule

// File: rtl/alu8_flag_reg.sv
// Status flag register with a load mask per bit, and the branch condition
// evaluator. The branch output reads the registered flags only.
module alu8_flag_reg
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [FLAG_W-1:0] nxt,
    input  logic [FLAG_W-1:0] mask,
    input  logic [2:0]        bit_sel,
    input  logic [1:0]        br_mode,
    output logic [FLAG_W-1:0] fq,
    output logic              br_taken
);
    genvar gi;
    generate
        for (gi = 0; gi < FLAG_W; gi++) begin : g_flag
            // One flag bit: cleared by reset, loaded only when its operation owns it
            always_ff @(posedge clk) begin
                if (!rst_n)                  fq[gi] <= 1'b0;
                else if (en && mask[gi])     fq[gi] <= nxt[gi];
            end
        end
    endgenerate

    logic sel_bit;

    // Evaluate the selected branch condition from the stored flags
    always_comb begin
        sel_bit = (bit_sel != 3'd7) ? fq[bit_sel] : 1'b0;
        case (br_mode)
            2'd0:    br_taken = sel_bit;
            2'd1:    br_taken = ~sel_bit;
            2'd2:    br_taken = ~(fq[F_N] ^ fq[F_V]);
            default: br_taken = fq[F_N] ^ fq[F_V];
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
// Top of the 8-bit ALU: combinational result and write-enable, registered
// flags that are loaded when op_en is high. It assumes the caller holds the
// operands stable from the falling edge until the next rising edge.
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DW-1:0]     rd_val,
    input  logic [DW-1:0]     rr_val,
    input  logic [2:0]        bit_sel,
    input  logic [1:0]        br_mode,
    output logic [DW-1:0]     result,
    output logic              wr_en,
    output logic [FLAG_W-1:0] flags,
    output logic              br_taken
);
    alu_op_e           op;
    logic              c_ar, h_ar, v_ar, sh_c;
    logic [FLAG_W-1:0] f_nxt, f_mask;

    assign op = alu_op_e'(op_sel);

    alu8_datapath #(.DW(DW)) u_dp (
        .op(op), .rd(rd_val), .rr(rr_val), .cin(flags[F_C]),
        .res(result), .c_ar(c_ar), .h_ar(h_ar), .v_ar(v_ar), .sh_c(sh_c)
    );

    alu8_flag_ctl #(.DW(DW)) u_ctl (
        .op(op), .res(result), .fq(flags), .c_ar(c_ar), .h_ar(h_ar),
        .v_ar(v_ar), .sh_c(sh_c), .bit_sel(bit_sel),
        .nxt(f_nxt), .mask(f_mask), .wr(wr_en)
    );

    alu8_flag_reg u_freg (
        .clk(clk), .rst_n(rst_n), .en(op_en), .nxt(f_nxt), .mask(f_mask),
        .bit_sel(bit_sel), .br_mode(br_mode), .fq(flags), .br_taken(br_taken)
    );
endmodule

// File: rtl/alu8_flags_chk.sv
// Property checker for alu8_flags, attached through bind. It observes the
// ports only.
module alu8_flags_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_en,
    input logic [OP_W-1:0]   op_sel,
    input logic [2:0]        bit_sel,
    input logic              wr_en,
    input logic [FLAG_W-1:0] flags
);
    p_compare_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CP || op_sel == OP_CPC) |-> !wr_en);

    p_chain_zero_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_sel == OP_SBC || op_sel == OP_CPC) && !flags[F_Z]) |=> !flags[F_Z]);

    p_logic_keeps_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_EOR))
        |=> (flags[F_C] == $past(flags[F_C])) && (flags[F_H] == $past(flags[F_H])));

    p_swap_ser_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_sel == OP_SWAP || op_sel == OP_SER)) |=> $stable(flags));

    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_sel == OP_FSET && bit_sel != 3'd7) |=> flags[$past(bit_sel)]);

    p_sign_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_sel <= OP_CPC) |=> (flags[F_S] == (flags[F_N] ^ flags[F_V])));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(flags));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
    .bit_sel(bit_sel), .wr_en(wr_en), .flags(flags)
);

// File: tb/tb_alu8_flags.sv
// Self-checking bench: a vector table walked by one loop, then directed tests
// for reset, flag forcing, idle hold, branch conditions and a chained compare.
module tb_alu8_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic [4:0] op_sel = '0;
    logic [7:0] rd_val = '0, rr_val = '0;
    logic [2:0] bit_sel = '0;
    logic [1:0] br_mode = '0;
    logic [7:0] result;
    logic       wr_en;
    logic [6:0] flags;
    logic       br_taken;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    alu8_flags dut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
        .rd_val(rd_val), .rr_val(rr_val), .bit_sel(bit_sel), .br_mode(br_mode),
        .result(result), .wr_en(wr_en), .flags(flags), .br_taken(br_taken)
    );

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic [6:0] fin;
        logic [7:0] res;
        logic       wr;
        logic [6:0] fout;
    } vec_t;

    localparam int NV = 26;
    // op, rd, rr, flags before, result, write, flags after (T H S V N Z C)
    localparam logic [43:0] VEC [0:NV-1] = '{
        {5'd0,  8'h0F, 8'h01, 7'h00, 8'h10, 1'b1, 7'h20}, // R1 half carry
        {5'd0,  8'h7F, 8'h01, 7'h00, 8'h80, 1'b1, 7'h2C}, // R1 overflow
        {5'd1,  8'hFF, 8'h00, 7'h01, 8'h00, 1'b1, 7'h23}, // R1 carry in
        {5'd2,  8'h10, 8'h01, 7'h00, 8'h0F, 1'b1, 7'h20}, // R2 half borrow
        {5'd2,  8'h80, 8'h01, 7'h00, 8'h7F, 1'b1, 7'h38}, // R2 overflow
        {5'd3,  8'h00, 8'h00, 7'h03, 8'hFF, 1'b1, 7'h35}, // R2 borrow in, R4
        {5'd5,  8'h05, 8'h05, 7'h00, 8'h00, 1'b0, 7'h00}, // R4 Z stays 0
        {5'd5,  8'h05, 8'h05, 7'h02, 8'h00, 1'b0, 7'h02}, // R4 Z stays 1
        {5'd4,  8'h03, 8'h05, 7'h00, 8'h00, 1'b0, 7'h35}, // R3 compare
        {5'd6,  8'hF0, 8'h3C, 7'h69, 8'h30, 1'b1, 7'h61}, // R5 keeps T H C
        {5'd8,  8'h55, 8'h55, 7'h01, 8'h00, 1'b1, 7'h03}, // R5 zero
        {5'd7,  8'h80, 8'h01, 7'h00, 8'h81, 1'b1, 7'h14}, // R5 negative
        {5'd9,  8'h0F, 8'h00, 7'h00, 8'hF0, 1'b1, 7'h15}, // R7 COM
        {5'd10, 8'h01, 8'h00, 7'h00, 8'hFF, 1'b1, 7'h35}, // R7 NEG
        {5'd10, 8'h00, 8'h00, 7'h01, 8'h00, 1'b1, 7'h02}, // R7 NEG zero
        {5'd10, 8'h80, 8'h00, 7'h00, 8'h80, 1'b1, 7'h0D}, // R7 NEG 0x80
        {5'd11, 8'h7F, 8'h00, 7'h01, 8'h80, 1'b1, 7'h0D}, // R6 INC
        {5'd12, 8'h00, 8'h00, 7'h00, 8'hFF, 1'b1, 7'h14}, // R6 DEC wrap
        {5'd12, 8'h80, 8'h00, 7'h00, 8'h7F, 1'b1, 7'h18}, // R6 DEC overflow
        {5'd13, 8'h81, 8'h00, 7'h00, 8'h02, 1'b1, 7'h19}, // R8 LSL
        {5'd15, 8'h40, 8'h00, 7'h01, 8'h81, 1'b1, 7'h0C}, // R8 ROL
        {5'd14, 8'h01, 8'h00, 7'h00, 8'h00, 1'b1, 7'h1B}, // R8 LSR
        {5'd16, 8'h02, 8'h00, 7'h01, 8'h81, 1'b1, 7'h0C}, // R8 ROR
        {5'd17, 8'h81, 8'h00, 7'h00, 8'hC0, 1'b1, 7'h15}, // R8 ASR
        {5'd18, 8'hA5, 8'h00, 7'h2B, 8'h5A, 1'b1, 7'h2B}, // R9 SWAP
        {5'd19, 8'h00, 8'h00, 7'h12, 8'hFF, 1'b1, 7'h12}  // R9 SER
    };

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:             return "R1";
            5'd2, 5'd3:             return "R2";
            5'd4, 5'd5:             return "R3";
            5'd6, 5'd7, 5'd8:       return "R5";
            5'd9, 5'd10:            return "R7";
            5'd11, 5'd12:           return "R6";
            5'd18, 5'd19:           return "R9";
            default:                return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Load all flags through FSET (20) / FCLR (21), one flag per cycle
    task automatic load_flags(input logic [6:0] val);
        for (int i = 0; i < 7; i++) begin
            op_sel  = val[i] ? 5'd20 : 5'd21;
            bit_sel = 3'(i);
            op_en   = 1'b1;
            @(negedge clk);
        end
        op_en = 1'b0;
    endtask

    // Apply one operation for one edge; result checked before the edge
    task automatic apply_op(input logic [4:0] op, input logic [7:0] a,
                            input logic [7:0] b, input logic [2:0] bs);
        op_sel = op; rd_val = a; rr_val = b; bit_sel = bs; op_en = 1'b1;
        @(negedge clk);
        op_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        vec_t v;
        repeat (3) @(negedge clk);
        check("R13", "flags in reset", 32'(flags), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13", "flags after reset", 32'(flags), 32'h0);

        for (int i = 0; i < NV; i++) begin
            v = vec_t'(VEC[i]);
            load_flags(v.fin);
            op_sel = v.op; rd_val = v.a; rr_val = v.b; bit_sel = 3'd7; op_en = 1'b1;
            #1;
            check(req_of(v.op), $sformatf("wr_en vec %0d", i), 32'(wr_en), 32'(v.wr));
            if (v.wr)
                check(req_of(v.op), $sformatf("result vec %0d", i), 32'(result), 32'(v.res));
            @(negedge clk);
            op_en = 1'b0;
            check(req_of(v.op), $sformatf("flags vec %0d", i), 32'(flags), 32'(v.fout));
            if (v.op != 5'd18 && v.op != 5'd19)
                check("R11", $sformatf("S rule vec %0d", i), 32'(flags[4]),
                      32'(flags[2] ^ flags[1+2-1+1] ));
        end

        // R10: single flag forcing, index 7 is a no-op, no write-back
        load_flags(7'h00);
        apply_op(5'd20, 8'h00, 8'h00, 3'd6);
        check("R10", "FSET T", 32'(flags), 32'h40);
        apply_op(5'd20, 8'h00, 8'h00, 3'd7);
        check("R10", "FSET index 7", 32'(flags), 32'h40);
        op_sel = 5'd21; bit_sel = 3'd6; #1;
        check("R10", "FCLR wr_en", 32'(wr_en), 32'h0);
        apply_op(5'd21, 8'h00, 8'h00, 3'd6);
        check("R10", "FCLR T", 32'(flags), 32'h00);

        // R13: op_en low leaves the flags untouched
        op_sel = 5'd0; rd_val = 8'hFF; rr_val = 8'h01; op_en = 1'b0;
        @(negedge clk);
        check("R13", "idle hold", 32'(flags), 32'h00);

        // R12: branch conditions
        load_flags(7'h04);
        br_mode = 2'd3; #1; check("R12", "LT with N", 32'(br_taken), 32'h1);
        br_mode = 2'd2; #1; check("R12", "GE with N", 32'(br_taken), 32'h0);
        @(negedge clk);
        load_flags(7'h0C);
        br_mode = 2'd2; #1; check("R12", "GE with N,V", 32'(br_taken), 32'h1);
        br_mode = 2'd3; #1; check("R12", "LT with N,V", 32'(br_taken), 32'h0);
        bit_sel = 3'd1; br_mode = 2'd0; #1; check("R12", "Z set test", 32'(br_taken), 32'h0);
        br_mode = 2'd1; #1; check("R12", "Z clear test", 32'(br_taken), 32'h1);
        bit_sel = 3'd7; br_mode = 2'd0; #1; check("R12", "index 7 test", 32'(br_taken), 32'h0);
        @(negedge clk);

        // R4: 16-bit compare chain, equal then unequal in the low byte
        load_flags(7'h00);
        apply_op(5'd4, 8'h34, 8'h34, 3'd7);
        apply_op(5'd5, 8'h12, 8'h12, 3'd7);
        check("R4", "chain equal Z", 32'(flags[1]), 32'h1);
        apply_op(5'd4, 8'h35, 8'h34, 3'd7);
        apply_op(5'd5, 8'h12, 8'h12, 3'd7);
        check("R4", "chain unequal Z", 32'(flags[1]), 32'h0);

        // R13: reset mid-run clears flags
        load_flags(7'h7F);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R13", "reset clears", 32'(flags), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule